// File: doc/BRIEF.md
# Double-Buffered Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a free-running timestamp counter. It compares the counter against an active period value and an active compare value. Software sets the block up over a simple synchronous register bus. That bus carries an address, a write strobe, write data, and read data that is decoded combinationally from the address. A control register holds the enable bits. It starts and stops the counter and gates the output.

Changing the waveform while it runs is safe. Software writes new period and compare values into a pair of shadow registers. A pending flag records that a write has been made. The active registers take the shadow values only on the clock edge where the counter returns to zero, so the current period is never cut short. While the counter is stopped, software loads the active registers directly.

Top module: `shadow_pwm`

## Requirements
- R1: After reset every register reads 0, the counter is stopped at 0, and the output is low.
- R2: The registers read back at these byte addresses: 0x00 timestamp counter (read only), 0x08 active period, 0x0C active compare, 0x10 shadow period, 0x14 shadow compare, 0x2A control (16 bits, zero-extended). Any other address reads 0.
- R3: When control bit 4 (run) is 1, the counter counts up by one per clock from 0 to the active period and then wraps to 0 on the next edge. When run is 0, the counter holds its value.
- R4: The output is high only when control bit 9 (mode) is 1 and either the counter is below the active compare value or the compare value is greater than or equal to the period. With mode at 0 the output is low.
- R5: When run is 0, writes to 0x08 and 0x0C load the active registers directly.
- R6: When run is 1, writes to 0x08 and 0x0C are ignored, and the active registers keep their values.
- R7: Any write to 0x10 or 0x14 sets a pending flag. On the edge where the counter wraps, if the flag is set, both shadow values are copied into the active registers and the flag clears. Without the flag, the active registers are left unchanged.
- R8: A shadow write made on the same cycle as a wrap is not lost. The flag stays set, and the new value moves to the active registers at the following wrap.
- R9: The minimum setting, period 1 with compare 1, gives a valid steady output. With compare 1 the output is constantly high. With compare 0 the output is constantly low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| pwm_out | output | 1 | PWM output |

## Verification
Suppose the counter or the active registers hold a wrong value. The output then shows a wrong edge within one period, and the counter readback differs on the very next clock. Suppose instead the pending flag is wrong. That shows only as a wrong or missing change in the active period or compare at the next wrap. The bench therefore compares readback and output against its model on every cycle, including cycles that line up exactly with a wrap.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
    localparam int CTL_W = 16;

    // byte addresses of the register map
    localparam logic [7:0] OFS_COUNT  = 8'h00;
    localparam logic [7:0] OFS_PER    = 8'h08;
    localparam logic [7:0] OFS_CMP    = 8'h0C;
    localparam logic [7:0] OFS_SH_PER = 8'h10;
    localparam logic [7:0] OFS_SH_CMP = 8'h14;
    localparam logic [7:0] OFS_CTL    = 8'h2A;

    // control register bit positions
    localparam int BIT_RUN  = 4;
    localparam int BIT_MODE = 9;
endpackage

// File: rtl/shadow_pwm_timer.sv
module shadow_pwm_timer
    import shadow_pwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] per_i,
    input  logic [DATA_W-1:0] cmp_i,
    output logic [DATA_W-1:0] count_o,
    output logic              boundary_o,
    output logic              pwm_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic wrap;

    assign wrap = run_i && (st_q.cnt >= per_i);

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (wrap) st_d.cnt = '0;
            else      st_d.cnt = st_q.cnt + DATA_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o    = st_q.cnt;
    assign boundary_o = wrap;
    assign pwm_o      = mode_i && ((st_q.cnt < cmp_i) || (cmp_i >= per_i));

    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> count_o == $past(count_o));

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && count_o >= per_i) |=> count_o == '0);

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && count_o < per_i) |=> count_o == $past(count_o) + DATA_W'(1));
endmodule

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs
    import shadow_pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              boundary_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] per_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic              run_o,
    output logic              mode_o
);
    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] per_act;
        logic [DATA_W-1:0] cmp_act;
        logic [DATA_W-1:0] sh_per;
        logic [DATA_W-1:0] sh_cmp;
        logic              pend;
    } regs_t;

    regs_t st_d, st_q;
    logic  running, xfer, shadow_wr;
    logic  hit_per, hit_cmp, hit_sper, hit_scmp, hit_ctl, hit_cnt;

    assign hit_cnt  = addr_i == ADDR_W'(OFS_COUNT);
    assign hit_per  = addr_i == ADDR_W'(OFS_PER);
    assign hit_cmp  = addr_i == ADDR_W'(OFS_CMP);
    assign hit_sper = addr_i == ADDR_W'(OFS_SH_PER);
    assign hit_scmp = addr_i == ADDR_W'(OFS_SH_CMP);
    assign hit_ctl  = addr_i == ADDR_W'(OFS_CTL);

    assign running   = st_q.ctl[BIT_RUN];
    assign xfer      = boundary_i && st_q.pend;
    assign shadow_wr = we_i && (hit_sper || hit_scmp);

    always_comb begin
        st_d = st_q;
        // transfer uses the shadow contents held before this edge
        if (xfer) begin
            st_d.per_act = st_q.sh_per;
            st_d.cmp_act = st_q.sh_cmp;
            st_d.pend    = 1'b0;
        end
        if (we_i) begin
            if (hit_ctl)              st_d.ctl     = wdata_i[CTL_W-1:0];
            if (hit_per && !running)  st_d.per_act = wdata_i;
            if (hit_cmp && !running)  st_d.cmp_act = wdata_i;
            if (hit_sper)             st_d.sh_per  = wdata_i;
            if (hit_scmp)             st_d.sh_cmp  = wdata_i;
            if (shadow_wr)            st_d.pend    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (hit_cnt)  rdata_o = count_i;
        if (hit_per)  rdata_o = st_q.per_act;
        if (hit_cmp)  rdata_o = st_q.cmp_act;
        if (hit_sper) rdata_o = st_q.sh_per;
        if (hit_scmp) rdata_o = st_q.sh_cmp;
        if (hit_ctl)  rdata_o = DATA_W'(st_q.ctl);
    end

    assign per_o  = st_q.per_act;
    assign cmp_o  = st_q.cmp_act;
    assign run_o  = running;
    assign mode_o = st_q.ctl[BIT_MODE];

    assert_active_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !boundary_i) |=> ($stable(per_o) && $stable(cmp_o)));

    assert_no_xfer_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !st_q.pend) |=> ($stable(per_o) && $stable(cmp_o)));

    assert_xfer_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && st_q.pend) |=> (per_o == $past(st_q.sh_per) && cmp_o == $past(st_q.sh_cmp)));

    assert_pend_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_wr |=> st_q.pend);
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
    import shadow_pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    logic [DATA_W-1:0] count, per, cmp;
    logic              boundary, run, mode;

    shadow_pwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .count_i    (count),
        .boundary_i (boundary),
        .rdata_o    (bus_rdata),
        .per_o      (per),
        .cmp_o      (cmp),
        .run_o      (run),
        .mode_o     (mode)
    );

    shadow_pwm_timer #(.DATA_W(DATA_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .mode_i     (mode),
        .per_i      (per),
        .cmp_i      (cmp),
        .count_o    (count),
        .boundary_o (boundary),
        .pwm_o      (pwm_out)
    );

    assert_low_without_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> !pwm_out);
endmodule

// File: tb/sim_shadow_pwm.sv
`timescale 1ns/1ps
module sim_shadow_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    longint unsigned m_cnt, m_per, m_cmp, m_sper, m_scmp;
    logic [15:0] m_ctl;
    bit m_pend;

    always #4 clk = ~clk;

    shadow_pwm u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm)
    );

    function automatic bit m_run();
        return m_ctl[4];
    endfunction

    function automatic longint unsigned exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_cnt;
            8'h08: return m_per;
            8'h0C: return m_cmp;
            8'h10: return m_sper;
            8'h14: return m_scmp;
            8'h2A: return longint'(m_ctl);
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_out();
        return m_ctl[9] && ((m_cnt < m_cmp) || (m_cmp >= m_per));
    endfunction

    task automatic model_edge(input logic [7:0] a, input bit w, input logic [31:0] d);
        bit wrap, xfer;
        longint unsigned o_sper, o_scmp;
        wrap = m_run() && (m_cnt >= m_per);
        xfer = wrap && m_pend;
        o_sper = m_sper; o_scmp = m_scmp;
        if (m_run()) m_cnt = wrap ? 0 : m_cnt + 1;
        if (xfer) begin m_per = o_sper; m_cmp = o_scmp; m_pend = 0; end
        if (w) begin
            if (a == 8'h08 && !m_run()) m_per = d;
            else if (a == 8'h0C && !m_run()) m_cmp = d;
            else if (a == 8'h10) begin m_sper = d; m_pend = 1; end
            else if (a == 8'h14) begin m_scmp = d; m_pend = 1; end
            else if (a == 8'h2A) m_ctl = d[15:0];
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (pwm !== exp_out()) begin
            errors++;
            $display("FAIL %s pwm_out actual=%0b expected=%0b", tag, pwm, exp_out());
        end
        checks++;
        if (longint'(rdata) != exp_rd(addr)) begin
            errors++;
            $display("FAIL %s rdata@%0h actual=%0h expected=%0h", tag, addr, rdata, exp_rd(addr));
        end
    endtask

    task automatic step(input logic [7:0] a, input bit w, input logic [31:0] d, input string tag);
        addr = a; we = w; wdata = d;
        @(posedge clk);
        model_edge(a, w, d);
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(input int n, input logic [7:0] a, input string tag);
        for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0, tag);
    endtask

    initial begin
        m_cnt = 0; m_per = 0; m_cmp = 0; m_sper = 0; m_scmp = 0; m_ctl = '0; m_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every register
        foreach (addr_list[i]) step(addr_list[i], 1'b0, 32'h0, "R1");
        // R5 / R2: direct loads while stopped, read back
        step(8'h08, 1'b1, 32'd4, "R5");
        step(8'h0C, 1'b1, 32'd2, "R5");
        step(8'h08, 1'b0, 32'h0, "R2");
        step(8'h0C, 1'b0, 32'h0, "R2");
        step(8'h04, 1'b0, 32'h0, "R2");
        // shadow values, pending before start
        step(8'h10, 1'b1, 32'd6, "R7");
        step(8'h14, 1'b1, 32'd3, "R7");
        step(8'h10, 1'b0, 32'h0, "R2");
        // start: mode, sync-disable bits, run
        step(8'h2A, 1'b1, 32'h02D0, "R3");
        step(8'h2A, 1'b0, 32'h0, "R2");
        idle(20, 8'h00, "R3");
        idle(12, 8'h08, "R7");
        // R6: active writes ignored while running
        step(8'h08, 1'b1, 32'd9, "R6");
        step(8'h0C, 1'b1, 32'd1, "R6");
        idle(10, 8'h0C, "R6");
        // R8: shadow write aligned to a wrap
        for (int g = 0; g < 50 && !(m_run() && m_cnt >= m_per); g++) step(8'h00, 1'b0, 32'h0, "R8");
        step(8'h10, 1'b1, 32'd3, "R8");
        idle(6, 8'h08, "R8");
        step(8'h14, 1'b1, 32'd5, "R8");
        for (int g = 0; g < 50 && !(m_run() && m_cnt >= m_per); g++) step(8'h00, 1'b0, 32'h0, "R8");
        step(8'h10, 1'b1, 32'd2, "R8");
        idle(12, 8'h08, "R8");
        idle(8, 8'h0C, "R4");
        // R4: mode off forces output low while counting
        step(8'h2A, 1'b1, 32'h0010, "R4");
        idle(8, 8'h00, "R4");
        // R3: stopped counter holds
        step(8'h2A, 1'b1, 32'h0000, "R3");
        idle(6, 8'h00, "R3");
        // R9: minimum setting
        step(8'h08, 1'b1, 32'd1, "R9");
        step(8'h0C, 1'b1, 32'd1, "R9");
        step(8'h2A, 1'b1, 32'h0210, "R9");
        idle(10, 8'h00, "R9");
        step(8'h2A, 1'b1, 32'h0000, "R9");
        step(8'h0C, 1'b1, 32'd0, "R9");
        step(8'h2A, 1'b1, 32'h0210, "R9");
        idle(10, 8'h00, "R9");
        // R4: compare below period gives a duty cycle
        step(8'h2A, 1'b1, 32'h0000, "R4");
        step(8'h08, 1'b1, 32'd7, "R4");
        step(8'h0C, 1'b1, 32'd3, "R4");
        step(8'h2A, 1'b1, 32'h0210, "R4");
        idle(24, 8'h00, "R4");
        we = 1'b0;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    logic [7:0] addr_list [6] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h2A};

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule